// File: doc/BRIEF.md
# Shared Clock Test Pin Controller

This block owns a single bidirectional pad that serves one of two roles. As an input it accepts a slow external clock and converts its rising edges into single-cycle tick enables for an interval-timer core. The external signal is first resynchronized to the system clock, so metastable or partial levels never reach the timer. As an output it places one of six internal clocks on the pad so that the clock can be observed or used to drive an external device.

A small control register sets the pad's role. The register holds three fields:
- an enable bit;
- a direction bit;
- a 3-bit source-select field.

After reset the pad is an input and is disabled. The output path is a plain combinational multiplexer with no glitch protection. Software is expected to follow a fixed order:
1. Hold the external target in reset.
2. Program the source-select field.
3. Set the direction to output.
4. Set the enable bit.
5. Release the target from reset.

Top module: `clkpin_ctl`

## Requirements
- R1: After reset the register reads 0, `pin_oe` and `pin_out` are low and no tick is produced.
- R2: A write with `wr_en` high stores bit 0 (enable), bit 1 (direction, 1 = output) and bits 4:2 (source select). After the clock edge, `rd_data` returns these five bits, and bits above 4 read as zero.
- R3: While the enable bit is 0, `pin_oe` and `pin_out` stay low and `tmr_tick` stays low, whatever the direction bit, `pin_in` or `src_clk` do.
- R4: When the pad is enabled and the direction is input, each rising edge of `pin_in` produces exactly one `tmr_tick` pulse, one system clock wide. Falling edges produce none. The tick is high in the cycle after the second system clock edge that samples the new high level.
- R5: In input mode, `pin_oe` is low, so the pad is tri-stated.
- R6: When the pad is enabled and the direction is output, `pin_oe` is high and `pin_out` equals `src_clk[sel]`. The select values map as follows: 0 = PLL1 reference, 1 = PLL2 reference, 2 = timer clock, 3 = real-time clock, 4 = UART fast clock, 5 = UART slow clock.
- R7: In output mode, select values 6 and 7 drive `pin_out` low.
- R8: The output path is purely combinational, with no retiming or glitch filtering. A change on the selected `src_clk` bit reaches `pin_out` without any system clock edge.
- R9: In output mode no tick is produced, whatever `pin_in` does.
- R10: Enabling input mode while `pin_in` is already high produces no tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | DW | Register write data |
| rd_data | output | DW | Register read-back |
| src_clk | input | NSRC | Internal clocks available for observation |
| pin_in | input | 1 | Pad input level |
| pin_out | output | 1 | Pad output level |
| pin_oe | output | 1 | Pad output enable |
| tmr_tick | output | 1 | Timer tick enable, one cycle per external rising edge |

## Verification
The bench builds the block with the default values: six sources, a 3-bit select, an 8-bit data word and a two-flop synchronizer. With six sources, select codes 6 and 7 fall outside the source set, so both constant-low codes are exercised. With an 8-bit word, the three always-zero read-back bits are visible. A two-flop chain fixes the tick latency at two edges, so the bench checks the exact cycle in which the tick appears. Random source patterns and random external pulse widths are combined with directed cases: enabling while the pad is high, toggling while disabled, and toggling in output mode.

// File: rtl/clkpin_ctl.sv
module clkpin_ctl #(
  parameter int DW    = 8,
  parameter int NSRC  = 6,
  parameter int SEL_W = 3,
  parameter int SYNC  = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data,
  input  logic [NSRC-1:0] src_clk,
  input  logic          pin_in,
  output logic          pin_out,
  output logic          pin_oe,
  output logic          tmr_tick
);
  localparam int REG_W = 2 + SEL_W;

  logic             en_q, dir_q;
  logic [SEL_W-1:0] sel_q;
  logic [SYNC-1:0]  sync_q;
  logic             last_q;
  logic             mux_o;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      en_q  <= 1'b0;
      dir_q <= 1'b0;
      sel_q <= '0;
    end else if (wr_en) begin
      en_q  <= wr_data[0];
      dir_q <= wr_data[1];
      sel_q <= wr_data[REG_W-1:2];
    end

  assign rd_data = {{(DW-REG_W){1'b0}}, sel_q, dir_q, en_q};

  always_comb begin
    mux_o = 1'b0;
    for (int i = 0; i < NSRC; i++)
      if (sel_q == SEL_W'(i)) mux_o = src_clk[i];
  end

  assign pin_oe  = en_q & dir_q;
  assign pin_out = pin_oe & mux_o;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC-2:0], pin_in};
      last_q <= sync_q[SYNC-1];
    end

  assign tmr_tick = en_q & ~dir_q & sync_q[SYNC-1] & ~last_q;
endmodule

// File: rtl/clkpin_ctl_chk.sv
module clkpin_ctl_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [DW-1:0] wr_data,
  input logic [DW-1:0] rd_data,
  input logic          pin_out,
  input logic          pin_oe,
  input logic          tmr_tick
);
  p_readback_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> rd_data == ($past(wr_data) & DW'(5'h1f)));
  p_off_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_data[0] |-> (!pin_oe && !pin_out && !tmr_tick));
  p_tick_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_tick |=> !tmr_tick);
  p_in_tristate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_data[1] |-> !pin_oe);
  p_const_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_oe && rd_data[4:2] >= 3'd6) |-> !pin_out);
  p_no_tick_out_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pin_oe |-> !tmr_tick);
endmodule

bind clkpin_ctl clkpin_ctl_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
  .rd_data(rd_data), .pin_out(pin_out), .pin_oe(pin_oe), .tmr_tick(tmr_tick)
);

// File: tb/clkpin_ctl_test.sv
module clkpin_ctl_test;
  logic       clk = 0, rst_n = 0, wr_en = 0, pin_in = 0;
  logic [7:0] wr_data = 0;
  logic [7:0] rd_data;
  logic [5:0] src_clk = 0;
  logic       pin_out, pin_oe, tmr_tick;
  int n_run = 0, n_fail = 0, ticks = 0, dbl = 0;
  logic prev_tick = 0;

  clkpin_ctl uut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .src_clk(src_clk), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .tmr_tick(tmr_tick));

  always #2 clk = ~clk;

  always @(negedge clk) begin
    if (tmr_tick) ticks++;
    if (tmr_tick && prev_tick) dbl++;
    prev_tick = tmr_tick;
  end

  function automatic logic exp_out(logic [2:0] s, logic [5:0] v);
    return (s < 3'd6) ? v[s] : 1'b0;
  endfunction

  task automatic chk(string req, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] v);
    @(negedge clk); wr_en = 1; wr_data = v;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic cycles(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(200000*4);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int t0, n;
    logic [2:0] s;
    void'($urandom(32'd1234));
    cycles(3); rst_n = 1; cycles(1);
    chk("R1 rd", rd_data, 0); chk("R1 oe", pin_oe, 0);
    chk("R1 out", pin_out, 0); chk("R1 ticks", ticks, 0);

    // R3 disabled: toggle pad, sources high
    src_clk = 6'h3f;
    for (int i = 0; i < 4; i++) begin pin_in = 1; cycles(4); pin_in = 0; cycles(4); end
    chk("R3 ticks", ticks, 0);
    wr(8'h02);
    chk("R3 oe dir=1", pin_oe, 0); chk("R3 out dir=1", pin_out, 0);

    // R2 readback
    wr(8'hff); chk("R2 mask", rd_data, 8'h1f);
    for (int i = 0; i < 8; i++) begin
      logic [7:0] v = 8'($urandom) & 8'hfc;
      wr(v); chk("R2 rand", rd_data, v & 8'h1f);
    end
    wr(8'h00);

    // R10 enable with pad high
    pin_in = 1; cycles(4); t0 = ticks;
    wr(8'h01); cycles(6);
    chk("R10 no tick", ticks - t0, 0);
    pin_in = 0; cycles(4);

    // R4 latency: tick after second edge
    t0 = ticks;
    pin_in = 1;
    @(negedge clk); chk("R4 lat1", tmr_tick, 0);
    @(negedge clk); chk("R4 lat2", tmr_tick, 1);
    @(negedge clk); chk("R4 lat3", tmr_tick, 0);
    cycles(3); pin_in = 0; cycles(5);
    chk("R4 fall none", ticks - t0, 1);
    chk("R5 oe", pin_oe, 0);

    // R4 random edge trains
    for (int k = 0; k < 5; k++) begin
      n = 3 + $urandom_range(0, 7); t0 = ticks;
      for (int i = 0; i < n; i++) begin
        pin_in = 1; cycles(3 + $urandom_range(0, 5));
        pin_in = 0; cycles(3 + $urandom_range(0, 5));
      end
      cycles(3);
      chk("R4 count", ticks - t0, n);
    end
    chk("R4 width", dbl, 0);

    // R6 output mux
    for (int i = 0; i < 30; i++) begin
      s = 3'($urandom_range(0, 5));
      src_clk = 6'($urandom);
      wr({3'b0, s, 2'b11});
      chk("R6 oe", pin_oe, 1);
      chk("R6 out", pin_out, exp_out(s, src_clk));
      src_clk[s] = ~src_clk[s]; #1;
      chk("R8 comb", pin_out, exp_out(s, src_clk));
    end

    // R9 no ticks in output mode
    t0 = ticks;
    for (int i = 0; i < 3; i++) begin pin_in = 1; cycles(4); pin_in = 0; cycles(4); end
    chk("R9 ticks", ticks - t0, 0);

    // R7 codes 6 and 7
    src_clk = 6'h3f;
    wr(8'h1b); chk("R7 sel6", pin_out, 0);
    wr(8'h1f); chk("R7 sel7", pin_out, 0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule